// File: doc/BRIEF.md
# Multi-Channel Timer Bank

A bank of general-purpose timers behind a simple register bus. Each channel counts ticks of one of two tick sources, a fast system tick or a slow always-on tick, after a per-channel divider. It compares the count against its own compare value. When the count reaches that value, the channel raises its bit in a shared interrupt status register. A shared enable register masks the status bits onto a single interrupt line. A shared acknowledge register clears them.

Each channel has four operating modes. One-shot stops the channel at the match. Repeat reloads the count to zero. Keep-going counts on past the match. Free-run counts without ever raising an event. The last channel is wide: its counter and compare are 64 bits, and it has extra high-word registers. Every other channel is 32 bits wide.

Software drives the block in a fixed sequence:
1. Stop the channel.
2. Acknowledge any stale status.
3. Program the divider, the compare value and the interrupt enable.
4. Write the control register with enable, clear and mode together.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register reads 0 once the reset-time counter clear has completed: interrupt enable, status, control, clock select, counter and compare. `irq` is low.
- R2: Bit n of the shared registers belongs to channel n. The registers sit at byte 0x00 (interrupt enable, read/write), 0x04 (status, read-only; writes are ignored) and 0x08 (acknowledge). Writing 1 to an acknowledge bit clears that status bit. Writing 0 leaves it unchanged. If a new event arrives in the same cycle as the acknowledge, the event wins.
- R3: `irq` is a registered output. It is high one cycle after any status bit is set while its enable bit is set, and it stays low while the enable bit is clear.
- R4: Channel n has a register window at byte 0x10 + 0x10*n, laid out as follows:

  | Offset | Register |
  |---|---|
  | 0x0 | control |
  | 0x4 | clock select |
  | 0x8 | counter (low word) |
  | 0xC | compare (low word) |

- R5: The control register has three fields:
  - bit 0 enables counting;
  - bit 1 is a self-clearing counter clear: the counter reads 0 afterwards;
  - bits 5:4 select the mode: 00 one-shot, 01 repeat, 10 keep-going, 11 free-run.
- R6: The clock select register has two fields:
  - bits 3:0 hold a divider code k, which divides the selected tick by k+1;
  - bit 4 selects the slow tick (1) instead of the system tick (0). The unselected tick has no effect.
- R7: With the selected tick held high, divider k and compare C (C ≥ 3), start the channel by writing enable and clear together. The status bit sets (k+1)·C+1 cycles after that write, and `irq` follows one cycle later.
- R8: In one-shot mode a match clears the enable bit. The counter then holds at the compare value.
- R9: In repeat mode a match reloads the counter to zero and counting continues, so the counter never reads C or more and the event recurs.
- R10: In keep-going mode the counter counts on past the compare value, and the enable bit stays set.
- R11: In free-run mode the counter keeps counting and the status bit never sets.
- R12: A compare value below 3 behaves as 3, though it reads back as written.
- R13: The last channel (index NUM_CH-1) has a 64-bit counter and compare. Their high words sit at byte offsets 0x18 (counter) and 0x1C (compare) of its window. A non-zero high compare word prevents a match on the low word alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| tick_sys | input | 1 | System tick enable |
| tick_slow | input | 1 | Slow always-on tick enable |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The assertions assume that ticks arrive only as single-cycle enables sampled on `clk`. They also assume that a channel is started by one control write carrying both enable and clear, and that no compare write happens while the channel counts. The stimulus keeps to this by always stopping a channel before reprogramming it. It holds the system tick high, pulses the slow tick only when the slow source is selected, and picks random compare values from 3 to 30 and divider codes from 0 to 3, so event times are exact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE  = 2'b00,
    MODE_LOOP  = 2'b01,
    MODE_RUNON = 2'b10,
    MODE_FREE  = 2'b11
  } tmr_mode_e;

  // shared register offsets inside window 0
  localparam logic [3:0] OFS_IEN  = 4'h0;
  localparam logic [3:0] OFS_ISTA = 4'h4;
  localparam logic [3:0] OFS_IACK = 4'h8;

  // per-channel register offsets
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CSEL = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h8;
  localparam logic [3:0] OFS_CMP  = 4'hC;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int CTRL_MODE_LO = 4;
  localparam int CSEL_SRC_BIT = 4;

  localparam int MIN_CMP = 3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic             src_slow,
  input  logic             tick_sys,
  input  logic             tick_slow,
  input  logic [DIV_W-1:0] div,
  output logic             step
);
  logic [DIV_W-1:0] pre_q;
  logic             sel_tick;
  logic             wrap;

  assign sel_tick = src_slow ? tick_slow : tick_sys;
  assign wrap     = (pre_q == div);
  assign step     = run && !clear && sel_tick && wrap;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
    end else if (run && sel_tick) begin
      pre_q <= wrap ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter bit WIDE  = 1'b0,
  parameter int DIV_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ctrl,
  input  logic        wr_csel,
  input  logic        wr_cmp_lo,
  input  logic        wr_cmp_hi,
  input  logic [31:0] wdata,
  input  logic        tick_sys,
  input  logic        tick_slow,
  output logic [31:0] ctrl_rd,
  output logic [31:0] csel_rd,
  output logic [63:0] cnt_rd,
  output logic [63:0] cmp_rd,
  output logic        hit
);
  localparam int CW = WIDE ? 64 : 32;

  logic             en_q;
  logic             clr_q;
  tmr_mode_e        mode_q;
  logic [DIV_W-1:0] div_q;
  logic             src_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cmp_q;
  logic [CW-1:0]    cmp_eff;
  logic [CW-1:0]    cnt_inc;
  logic             step;

  assign cmp_eff = (cmp_q < CW'(MIN_CMP)) ? CW'(MIN_CMP) : cmp_q;
  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = step && (cnt_inc == cmp_eff) && (mode_q != MODE_FREE);

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .clear     (clr_q),
    .run       (en_q),
    .src_slow  (src_q),
    .tick_sys  (tick_sys),
    .tick_slow (tick_slow),
    .div       (div_q),
    .step      (step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      clr_q  <= 1'b1;
      mode_q <= MODE_ONCE;
      div_q  <= '0;
      src_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (clr_q) begin
        cnt_q <= '0;
        clr_q <= 1'b0;
      end else if (step) begin
        if (hit) begin
          unique case (mode_q)
            MODE_ONCE: begin
              cnt_q <= cnt_inc;
              en_q  <= 1'b0;
            end
            MODE_LOOP: cnt_q <= '0;
            default:   cnt_q <= cnt_inc;
          endcase
        end else begin
          cnt_q <= cnt_inc;
        end
      end
      if (wr_ctrl) begin
        en_q   <= wdata[CTRL_EN_BIT];
        mode_q <= tmr_mode_e'(wdata[CTRL_MODE_LO+1:CTRL_MODE_LO]);
        if (wdata[CTRL_CLR_BIT]) clr_q <= 1'b1;
      end
      if (wr_csel) begin
        div_q <= wdata[DIV_W-1:0];
        src_q <= wdata[CSEL_SRC_BIT];
      end
    end
  end

  generate
    if (WIDE) begin : g_wide_cmp
      always_ff @(posedge clk) begin
        if (rst) begin
          cmp_q <= '0;
        end else begin
          if (wr_cmp_lo) cmp_q[31:0]  <= wdata;
          if (wr_cmp_hi) cmp_q[63:32] <= wdata;
        end
      end
    end else begin : g_narrow_cmp
      always_ff @(posedge clk) begin
        if (rst) cmp_q <= '0;
        else if (wr_cmp_lo) cmp_q <= wdata;
      end
    end
  endgenerate

  assign ctrl_rd = {26'b0, mode_q, 2'b00, clr_q, en_q};
  assign csel_rd = {{(31-DIV_W){1'b0}}, src_q, div_q};
  assign cnt_rd  = 64'(cnt_q);
  assign cmp_rd  = 64'(cmp_q);

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    $past(clr_q) |-> (cnt_q == '0)) else $error("clear"); // R5
  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    $past(hit && mode_q == MODE_ONCE && !wr_ctrl) |-> !en_q) else $error("oneshot"); // R8
  AST_LOOP_RELOADS: assert property (@(posedge clk) disable iff (rst)
    $past(hit && mode_q == MODE_LOOP) |-> (cnt_q == '0)) else $error("loop"); // R9
  AST_RUNON_PASSES: assert property (@(posedge clk) disable iff (rst)
    $past(hit && mode_q == MODE_RUNON) |-> (cnt_q == CW'($past(cnt_q) + 1'b1))) else $error("runon"); // R10
  AST_MIN_COMPARE: assert property (@(posedge clk) disable iff (rst)
    hit |-> (cnt_inc >= CW'(MIN_CMP))) else $error("mincmp"); // R12
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_sys,
  input  logic              tick_slow,
  output logic              irq
);
  localparam int WIN_W    = ADDR_W - 4;
  localparam int WIDE_IDX = NUM_CH - 1;
  localparam int HI_WIN   = NUM_CH + 1;  // wide base + 0x18 lands here

  logic [WIN_W-1:0]  win;
  logic [3:0]        ofs;
  logic              wr_en;
  logic [NUM_CH-1:0] ien_q;
  logic [NUM_CH-1:0] sta_q;
  logic [NUM_CH-1:0] hits;
  logic [NUM_CH-1:0] ack_mask;
  logic [31:0]       rd_mux;
  logic [31:0]       ctrl_rd [NUM_CH];
  logic [31:0]       csel_rd [NUM_CH];
  logic [63:0]       cnt_rd  [NUM_CH];
  logic [63:0]       cmp_rd  [NUM_CH];
  logic              shared_win;
  logic              hi_win;

  assign win        = bus_addr[ADDR_W-1:4];
  assign ofs        = bus_addr[3:0];
  assign wr_en      = bus_sel && bus_wr;
  assign shared_win = (win == '0);
  assign hi_win     = (win == WIN_W'(HI_WIN));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic in_win;
      assign in_win = (win == WIN_W'(gi + 1));
      tmr_channel #(.WIDE(gi == WIDE_IDX), .DIV_W(DIV_W)) u_ch (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_en && in_win && ofs == OFS_CTRL),
        .wr_csel   (wr_en && in_win && ofs == OFS_CSEL),
        .wr_cmp_lo (wr_en && in_win && ofs == OFS_CMP),
        .wr_cmp_hi ((gi == WIDE_IDX) && wr_en && hi_win && ofs == OFS_CMP),
        .wdata     (bus_wdata),
        .tick_sys  (tick_sys),
        .tick_slow (tick_slow),
        .ctrl_rd   (ctrl_rd[gi]),
        .csel_rd   (csel_rd[gi]),
        .cnt_rd    (cnt_rd[gi]),
        .cmp_rd    (cmp_rd[gi]),
        .hit       (hits[gi])
      );

      AST_STATUS_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(sta_q[gi]) |-> $past(hits[gi])) else $error("status cause"); // R2
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && shared_win && ofs == OFS_IACK && bus_wdata[gi] && !hits[gi])
        |-> !sta_q[gi]) else $error("ack"); // R2
    end
  endgenerate

  assign ack_mask = (wr_en && shared_win && ofs == OFS_IACK) ? bus_wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= '0;
      sta_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_en && shared_win && ofs == OFS_IEN) ien_q <= bus_wdata[NUM_CH-1:0];
      sta_q <= (sta_q & ~ack_mask) | hits;
      irq   <= |(sta_q & ien_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (shared_win) begin
      case (ofs)
        OFS_IEN:  rd_mux = 32'(ien_q);
        OFS_ISTA: rd_mux = 32'(sta_q);
        default:  rd_mux = '0;
      endcase
    end else if (hi_win) begin
      case (ofs)
        OFS_CNT: rd_mux = cnt_rd[WIDE_IDX][63:32];
        OFS_CMP: rd_mux = cmp_rd[WIDE_IDX][63:32];
        default: rd_mux = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (win == WIN_W'(i + 1)) begin
          case (ofs)
            OFS_CTRL: rd_mux = ctrl_rd[i];
            OFS_CSEL: rd_mux = csel_rd[i];
            OFS_CNT:  rd_mux = cnt_rd[i][31:0];
            OFS_CMP:  rd_mux = cmp_rd[i][31:0];
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0 && $past(ien_q == '0)) |-> !irq) else $error("irq mask"); // R3
endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_sys = 1'b1;
  logic        tick_slow = 1'b0;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  tmr_bank i_tmr_bank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_sys(tick_sys), .tick_slow(tick_slow), .irq(irq)
  );

  function automatic logic [7:0] ch_addr(int ch, int o);
    return 8'(16 + 16 * ch + o);
  endfunction

  function automatic int irq_delay(int c, int d);
    int ce = (c < 3) ? 3 : c;
    return (d + 1) * ce + 2;  // negedges after the start write
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // stop, acknowledge, program; returns right after the start write
  task automatic start(int ch, int c, int d, int mode, bit slow);
    wr(ch_addr(ch, 0), 32'h0);
    wr(8'h08, 32'hFF);
    wr(ch_addr(ch, 4), {27'b0, slow, 4'(d)});
    wr(ch_addr(ch, 12), 32'(c));
    wr(8'h00, 32'(1 << ch));
    wr(ch_addr(ch, 0), 32'((mode << 4) | 3));
  endtask

  // checks irq low one cycle before, high at the expected cycle
  task automatic time_check(string req, int c, int d);
    int n = irq_delay(c, d);
    idle(n - 1);
    check(req, irq, 1'b0);
    idle(1);
    check(req, irq, 1'b1);
  endtask

  initial begin
    logic [31:0] v;
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    idle(2);
    // R1 reset state
    check("R1 irq", irq, 0);
    rd(8'h00, v); check("R1 ien", v, 0);
    rd(8'h04, v); check("R1 sta", v, 0);
    rd(ch_addr(0, 0), v); check("R1 ctrl", v, 0);
    rd(ch_addr(2, 4), v); check("R1 csel", v, 0);
    rd(ch_addr(3, 8), v); check("R1 cnt", v, 0);
    rd(ch_addr(5, 12), v); check("R1 cmp", v, 0);

    // R7 directed timing, R4 window for channel 1
    start(1, 5, 0, 0, 0);
    time_check("R7 ch1 c5 d0", 5, 0);
    // R8 one-shot aftermath
    rd(ch_addr(1, 0), v); check("R8 enable cleared", v, 0);
    rd(ch_addr(1, 8), v); check("R8 counter holds", v, 5);
    // R2 ack 0 no effect, status write ignored
    wr(8'h08, 32'h0);
    rd(8'h04, v); check("R2 ack0", v, 32'h2);
    wr(8'h04, 32'h0);
    rd(8'h04, v); check("R2 sta ro", v, 32'h2);
    // R3 masked irq
    wr(8'h00, 32'h0);
    idle(2); check("R3 masked", irq, 0);
    wr(8'h08, 32'h2);
    rd(8'h04, v); check("R2 ack1", v, 0);

    // R12 compare below minimum
    start(2, 1, 0, 0, 0);
    time_check("R12 cmp1", 1, 0);
    rd(ch_addr(2, 8), v); check("R12 counter at 3", v, 3);
    rd(ch_addr(2, 12), v); check("R12 readback", v, 1);

    // R6/R7 random timing with divider
    for (int it = 0; it < 10; it++) begin
      int ch = $urandom_range(0, 4);
      int c  = $urandom_range(3, 30);
      int d  = $urandom_range(0, 3);
      start(ch, c, d, 0, 0);
      time_check($sformatf("R7 ch%0d c%0d d%0d", ch, c, d), c, d);
      rd(ch_addr(ch, 4), v); check("R6 csel readback", v, 32'(d));
    end

    // R9 repeat
    start(0, 5, 0, 1, 0);
    time_check("R9 first", 5, 0);
    for (int k = 0; k < 4; k++) begin
      rd(ch_addr(0, 8), v); check("R9 cnt below cmp", 32'(v < 5), 1);
    end
    wr(8'h08, 32'h1);
    idle(12);
    rd(8'h04, v); check("R9 recurs", v[0], 1);

    // R10 keep-going
    start(3, 5, 0, 2, 0);
    time_check("R10 event", 5, 0);
    idle(10);
    rd(ch_addr(3, 8), v); check("R10 past cmp", 32'(v > 5), 1);
    rd(ch_addr(3, 0), v); check("R10 enabled", v[0], 1);

    // R11 free-run
    start(4, 4, 0, 3, 0);
    idle(30);
    check("R11 irq", irq, 0);
    rd(8'h04, v); check("R11 sta", v[4], 0);
    rd(ch_addr(4, 8), v); check("R11 counting", 32'(v > 4), 1);

    // R6 slow source
    start(1, 3, 0, 0, 1);
    idle(20);
    rd(ch_addr(1, 8), v); check("R6 slow idle", v, 0);
    tick_slow = 1; idle(2); tick_slow = 0;
    rd(ch_addr(1, 8), v); check("R6 slow counts", v, 2);

    // R13 wide channel
    wr(ch_addr(5, 0), 32'h0);
    wr(8'h78 + 8'h04, 32'h1);
    start(5, 4, 0, 2, 0);
    idle(30);
    check("R13 hi blocks", irq, 0);
    rd(8'h7C, v); check("R13 cmp hi", v, 1);
    rd(8'h78, v); check("R13 cnt hi", v, 0);
    rd(ch_addr(5, 8), v); check("R13 cnt lo", 32'(v > 4), 1);

    // R5 clear zeroes counter
    wr(ch_addr(5, 0), 32'h2);
    idle(2);
    rd(ch_addr(5, 8), v); check("R5 clear", v, 0);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule